// File: doc/BRIEF.md
# Delta-Encoding Bit-Stream Packer

This block takes a stream of fixed-width unsigned values and packs them into 32-bit output words with no gaps between them. Every value takes exactly as many bits as its encoded form needs. Bits fill each word from bit 0 upward. A value that does not fit in the rest of a word continues at bit 0 of the next word. Both the input and the output use a valid/ready handshake.

With the delta mode input high, the block replaces each value with a variable-length code for its difference from the previous value. The first value of a stream is sent raw and becomes the base for the differences that follow. A code is built in this order: a 5-bit count of magnitude bits, then a sign bit, then the magnitude. A difference of zero shrinks to the count field alone.

A flush pulse closes the stream. Any partial word is padded with zeros and sent with a last flag. The block then starts over with an empty accumulator and no delta base.

Top module: `dpk_packer`

## Requirements
- R1: While reset is high and after it is released, out_valid is 0 and in_ready is 1.
- R2: When delta_mode is 0, each accepted value adds exactly VAL_W bits to the stream, least significant bit first. The stream fills each output word from bit 0 upward with no padding. A value that crosses a word boundary continues at bit 0 of the next word.
- R3: When delta_mode is 1, the first value after reset or after a flush is sent raw as VAL_W bits.
- R4: When delta_mode is 1 and a base exists, the difference d is the current value minus the previous accepted value. The code is written into the stream in this order:
  - a 5-bit field L, equal to the bit length of |d|, least significant bit first;
  - one sign bit, which is 1 when the current value is below the previous one;
  - the L low bits of |d|, least significant bit first.
- R5: A zero difference is sent as the 5-bit field L = 0 only, with no sign bit and no magnitude bits.
- R6: A flush pulse sends any partial word with its unused high bits zero and out_last = 1. The accumulator then empties, so the next value starts at bit 0 of a new word. A flush with an empty accumulator sends no word.
- R7: A flush clears the delta base, so the next value in delta mode is sent raw.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R9: in_ready is 0 while a flush is pending. It is also 0 while WORD_W or more bits wait in the accumulator, which happens when the output register cannot take the waiting word.
- R10: Every full word sent other than by a flush has out_last = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| delta_mode | input | 1 | 1 selects difference coding; change only when the block is idle after a flush |
| flush | input | 1 | Pulse that closes the current stream |
| in_valid | input | 1 | Input value valid |
| in_data | input | VAL_W | Input value |
| in_ready | output | 1 | Block can accept a value |
| out_ready | input | 1 | Downstream can accept a word |
| out_valid | output | 1 | Output word valid |
| out_data | output | WORD_W | Packed output word |
| out_last | output | 1 | Word closes a flushed stream |

## Verification
The bench builds the block with its defaults: 17-bit values, 32-bit words and difference coding enabled. With these widths, raw values land on every offset within a word. A run of 32 raw values fills exactly 17 words, which tests a flush on an empty accumulator. A swing from 0x1FFFF down to 0 gives the longest difference code, 23 bits, and the largest negative difference. Holding out_ready low lets the accumulator reach WORD_W bits, which exercises the input stall.

// File: rtl/dpk_pkg.sv
package dpk_pkg;
  // Number of bits needed to hold x (0 for x == 0).
  function automatic logic [5:0] bit_len32(input logic [31:0] x);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) begin
      if (x[i]) n = 6'(i + 1);
    end
    return n;
  endfunction
endpackage

// File: rtl/dpk_encoder.sv
module dpk_encoder
  import dpk_pkg::*;
#(
  parameter int VAL_W     = 17,
  parameter int LEN_W     = 5,
  parameter int CODE_W    = 23,
  parameter int CNT_W     = 6,
  parameter bit HAS_DELTA = 1'b1
) (
  input  logic [VAL_W-1:0]  val,
  input  logic [VAL_W-1:0]  prev,
  input  logic              base_ok,
  input  logic              delta_mode,
  output logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  code_len
);
  localparam logic [CNT_W-1:0] RAW_LEN  = CNT_W'(VAL_W);
  localparam logic [CNT_W-1:0] ZERO_LEN = CNT_W'(LEN_W);
  localparam logic [CNT_W-1:0] HDR_LEN  = CNT_W'(LEN_W + 1);

  generate
    if (HAS_DELTA) begin : g_delta
      logic             neg;
      logic [VAL_W-1:0] mag;
      logic [5:0]       nbits;
      always_comb begin
        neg   = (val < prev);
        mag   = neg ? (prev - val) : (val - prev);
        nbits = bit_len32(32'(mag));
        if (delta_mode && base_ok) begin
          // stream order from bit 0: length field, sign, magnitude
          code     = (CODE_W'(mag) << (LEN_W + 1)) | (CODE_W'(neg) << LEN_W) | CODE_W'(nbits);
          code_len = (nbits == 6'd0) ? ZERO_LEN : HDR_LEN + CNT_W'(nbits);
        end else begin
          code     = CODE_W'(val);
          code_len = RAW_LEN;
        end
      end
    end else begin : g_raw
      assign code     = CODE_W'(val);
      assign code_len = RAW_LEN;
    end
  endgenerate
endmodule

// File: rtl/dpk_accum.sv
module dpk_accum #(
  parameter int WORD_W = 32,
  parameter int CODE_W = 23,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [CODE_W-1:0] code,
  input  logic [CNT_W-1:0]  code_len,
  input  logic              pop,
  input  logic              clear,
  output logic [WORD_W-1:0] word_lo,
  output logic [CNT_W-1:0]  cnt
);
  localparam int ACC_W = WORD_W + CODE_W;

  logic [ACC_W-1:0] acc;

  // push happens only while cnt < WORD_W and pop only while cnt >= WORD_W,
  // so the two never meet in one cycle; bits above cnt are always zero.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= '0;
      cnt <= '0;
    end else if (push) begin
      acc <= acc | (ACC_W'(code) << cnt);
      cnt <= cnt + code_len;
    end else if (pop) begin
      acc <= acc >> WORD_W;
      cnt <= cnt - CNT_W'(WORD_W);
    end
  end

  assign word_lo = acc[WORD_W-1:0];
endmodule

// File: rtl/dpk_wordout.sv
module dpk_wordout #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] data,
  input  logic              last,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= data;
      out_last  <= last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dpk_packer.sv
module dpk_packer #(
  parameter int VAL_W     = 17,
  parameter int WORD_W    = 32,
  parameter int LEN_W     = 5,
  parameter bit HAS_DELTA = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              delta_mode,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [VAL_W-1:0]  in_data,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  localparam int CODE_W = HAS_DELTA ? (LEN_W + 1 + VAL_W) : VAL_W;
  localparam int ACC_W  = WORD_W + CODE_W;
  localparam int CNT_W  = $clog2(ACC_W + 1);

  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  code_len;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] word_lo;
  logic [VAL_W-1:0]  prev;
  logic              base_ok;
  logic              flush_pend;
  logic              can_load, has_word, pop, flush_done, emit_part, push;

  assign has_word   = (cnt >= CNT_W'(WORD_W));
  assign can_load   = !out_valid || out_ready;
  assign pop        = can_load && has_word;
  assign flush_done = flush_pend && !has_word && can_load;
  assign emit_part  = flush_done && (cnt != '0);
  assign in_ready   = !flush_pend && !has_word;
  assign push       = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_pend <= 1'b0;
      base_ok    <= 1'b0;
      prev       <= '0;
    end else begin
      flush_pend <= (flush_pend && !flush_done) || flush;
      if (push) begin
        prev    <= in_data;
        base_ok <= 1'b1;
      end else if (flush_done) begin
        base_ok <= 1'b0;
      end
    end
  end

  dpk_encoder #(
    .VAL_W(VAL_W), .LEN_W(LEN_W), .CODE_W(CODE_W), .CNT_W(CNT_W), .HAS_DELTA(HAS_DELTA)
  ) u_enc (
    .val(in_data), .prev(prev), .base_ok(base_ok), .delta_mode(delta_mode),
    .code(code), .code_len(code_len)
  );

  dpk_accum #(
    .WORD_W(WORD_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
  ) u_acc (
    .clk(clk), .rst(rst), .push(push), .code(code), .code_len(code_len),
    .pop(pop), .clear(flush_done), .word_lo(word_lo), .cnt(cnt)
  );

  dpk_wordout #(
    .WORD_W(WORD_W)
  ) u_out (
    .clk(clk), .rst(rst), .load(pop || emit_part), .data(word_lo), .last(emit_part),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: rtl/dpk_packer_chk.sv
module dpk_packer_chk #(
  parameter int WORD_W = 32,
  parameter int CODE_W = 23,
  parameter int ACC_W  = 55,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              flush_pend,
  input logic              in_ready,
  input logic              push,
  input logic [CNT_W-1:0]  cnt,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_last
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(ACC_W)); // R9
  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !in_ready); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R8
  AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (rst)
    flush_pend |=> (cnt <= $past(cnt))); // R6
  AST_PUSH_BOUND: assert property (@(posedge clk) disable iff (rst)
    push |=> (cnt <= $past(cnt) + CNT_W'(CODE_W))); // R2
endmodule

bind dpk_packer dpk_packer_chk #(
  .WORD_W(WORD_W), .CODE_W(CODE_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .flush_pend(flush_pend), .in_ready(in_ready),
  .push(push), .cnt(cnt), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last)
);

// File: tb/sim_dpk_packer.sv
module sim_dpk_packer;
  localparam int VAL_W  = 17;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              delta_mode = 1'b0;
  logic              flush = 1'b0;
  logic              in_valid = 1'b0;
  logic [VAL_W-1:0]  in_data = '0;
  logic              in_ready;
  logic              out_ready = 1'b0;
  logic              out_valid;
  logic [WORD_W-1:0] out_data;
  logic              out_last;

  always #5 clk = ~clk;

  dpk_packer #(.VAL_W(VAL_W), .WORD_W(WORD_W), .LEN_W(LEN_W), .HAS_DELTA(1'b1)) u0 (
    .clk(clk), .rst(rst), .delta_mode(delta_mode), .flush(flush), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_unexp = 0;
  int cyc = 0;
  bit stall = 1'b0;
  bit bp = 1'b0;

  logic [WORD_W-1:0] exp_w[$];
  bit                exp_l[$];
  string             exp_t[$];

  bit               mq[$];
  bit               m_base = 1'b0;
  logic [VAL_W-1:0] m_prev = '0;

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic put_bits(logic [31:0] v, int n);
    for (int i = 0; i < n; i++) mq.push_back(v[i]);
  endtask

  task automatic model_words(string tag);
    logic [WORD_W-1:0] w;
    while (mq.size() >= WORD_W) begin
      for (int i = 0; i < WORD_W; i++) w[i] = mq.pop_front();
      exp_w.push_back(w); exp_l.push_back(1'b0); exp_t.push_back(tag);
    end
  endtask

  task automatic model_value(logic [VAL_W-1:0] v, bit dm, string tag);
    int d, mag, len;
    if (dm && m_base) begin
      d   = int'(v) - int'(m_prev);
      mag = (d < 0) ? -d : d;
      len = 0;
      for (int i = 0; i < 32; i++) if (mag[i]) len = i + 1;
      put_bits(32'(len), LEN_W);
      if (len > 0) begin
        put_bits({31'd0, d < 0}, 1);
        put_bits(32'(mag), len);
      end
    end else begin
      put_bits(32'(v), VAL_W);
    end
    m_base = 1'b1;
    m_prev = v;
    model_words(tag);
  endtask

  task automatic model_flush(string tag);
    logic [WORD_W-1:0] w;
    if (mq.size() > 0) begin
      while (mq.size() < WORD_W) mq.push_back(1'b0);
      for (int i = 0; i < WORD_W; i++) w[i] = mq.pop_front();
      exp_w.push_back(w); exp_l.push_back(1'b1); exp_t.push_back(tag);
    end
    m_base = 1'b0;
  endtask

  task automatic send(logic [VAL_W-1:0] v, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    model_value(v, delta_mode, tag);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic do_flush(string tag);
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1;
    flush = 1'b0;
    model_flush(tag);
    @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R9", "in_ready during pending flush", 64'(in_ready), 64'd0);
  endtask

  task automatic wait_drain();
    int t;
    t = 0;
    while (exp_w.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor: sets out_ready for the coming edge, then compares
  bit               hold_prev = 1'b0;
  logic [WORD_W-1:0] pd;
  bit               pl;
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      out_ready = stall ? 1'b0 : (bp ? (cyc % 3 != 0) : 1'b1);
      if (hold_prev)
        check(out_valid && out_data == pd && out_last == pl, "R8", "stalled word changed",
              {out_valid, out_last, 30'd0, out_data}, {1'b1, pl, 30'd0, pd});
      hold_prev = out_valid && !out_ready;
      pd = out_data;
      pl = out_last;
      if (out_valid && out_ready) begin
        if (exp_w.size() == 0) begin
          n_unexp++;
          check(1'b0, "R6", "unexpected word", 64'(out_data), 64'd0);
        end else begin
          logic [WORD_W-1:0] ew;
          bit el;
          string et;
          ew = exp_w.pop_front(); el = exp_l.pop_front(); et = exp_t.pop_front();
          check(out_data == ew, et, "word data", 64'(out_data), 64'(ew));
          check(out_last == el, el ? "R6" : "R10", "last flag", 64'(out_last), 64'(el));
        end
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

    // raw packing across word boundaries with backpressure
    bp = 1'b1;
    send(17'h1FFFF, "R2"); send(17'h00001, "R2"); send(17'h0ABCD, "R2");
    send(17'h15555, "R2"); send(17'h00000, "R2"); send(17'h1F0F0, "R2");
    send(17'h12345, "R2");
    do_flush("R6");
    wait_drain();

    // difference coding
    delta_mode = 1'b1;
    send(17'd100, "R3");
    send(17'd100, "R5");
    send(17'd90, "R4");
    send(17'h1FFFF, "R4");
    send(17'h00000, "R4");
    send(17'd5, "R4");
    do_flush("R6");
    // base cleared by flush
    send(17'd1000, "R7");
    send(17'd1003, "R7");
    do_flush("R7");
    wait_drain();

    // stall the output until the accumulator holds a full word
    delta_mode = 1'b0;
    bp = 1'b0;
    stall = 1'b1;
    send(17'h0F00F, "R9"); send(17'h10101, "R9"); send(17'h07E7E, "R9"); send(17'h1C3C3, "R9");
    @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R9", "in_ready with full word waiting", 64'(in_ready), 64'd0);
    repeat (5) @(negedge clk);
    stall = 1'b0;
    do_flush("R6");
    wait_drain();

    // 32 raw values = 17 full words; flush must add nothing
    for (int i = 0; i < 32; i++) send(VAL_W'(i * 4111 + 5), "R2");
    do_flush("R6");
    wait_drain();
    repeat (20) @(negedge clk);
    check(exp_w.size() == 0, "R6", "words still expected", 64'(exp_w.size()), 64'd0);
    check(n_unexp == 0, "R6", "extra words after empty flush", 64'(n_unexp), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule